// File: doc/BRIEF.md
# Watchdog Timer with Reset Status

This block is an 8-bit up-counter that runs in one of two modes. In watchdog mode, a wrap of the counter from 0xFF to 0x00 sets a sticky overflow flag. If software has enabled it, the wrap also drives an internal chip reset pulse of fixed length. In interval mode, the same wrap raises a one-cycle interrupt and the counter keeps counting.

Software reaches three registers through a simple bus. The bus has a 2-bit address, write and read enables, a 16-bit write word and an 8-bit read word. Address 0 is the counter. Address 1 is the control register: bit 6 selects the mode (1 for watchdog, 0 for interval) and bit 5 enables counting; the other bits read 0. Address 2 is the reset status register: bit 7 is the overflow flag and bit 6 is the reset enable. Address 3 reads 0.

The reset status register is protected in two ways. It accepts a write only with a key in the upper byte of the write word. The reset pulse that the watchdog itself produces does not clear it. The counter advances only on cycles where the count-enable tick is high.

Top module: `wdt_rststat`

## Requirements
- R1: A low reset pin, or a cycle with standby high, returns the block to its initial state. The status register then reads 0x1F, the counter and the control register read 0x00, and the internal reset output is low.
- R2: With control bit 5 at 1, the counter increments by one on each clock edge where tick is high. With bit 5 at 0 it holds its value.
- R3: In watchdog mode (control bit 6 = 1), a counter wrap from 0xFF to 0x00 sets status bit 7.
- R4: In interval mode (control bit 6 = 0), a wrap leaves status bit 7 alone and raises the interval interrupt for exactly one cycle. The counter keeps running.
- R5: When status bit 6 is 1, a watchdog-mode wrap drives the internal reset high for exactly 8 cycles, starting in the cycle after the wrap. During those cycles the counter and the control register stay at 0x00, and writes to them are ignored.
- R6: When status bit 6 is 0, a watchdog-mode wrap leaves the internal reset low. It returns the counter and the control register to 0x00, so the timer stops.
- R7: The internal reset pulse does not change status bits 7 and 6.
- R8: Status bit 7 is cleared only by a keyed write with bit 7 = 0 that follows a read of the status register which returned bit 7 = 1. A write of 0 with no such read has no effect, and writing 1 to bit 7 has no effect.
- R9: An overflow that occurs after the arming read cancels that read. The next write of 0 then leaves the flag set.
- R10: A write to the status register takes effect only when write-word bits 15:8 equal 0x5A. Any other write to it is ignored.
- R11: Status bit 5 always reads 0 and bits 4:0 always read 1, whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_pin_n | input | 1 | Asynchronous active-low reset pin |
| standby | input | 1 | Standby indication; returns the block to its initial state |
| tick | input | 1 | Count-enable tick |
| addr | input | 2 | Register address (0 counter, 1 control, 2 status) |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write word; bits 15:8 carry the key for the status register |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, combinational, 0 when rd_en is low |
| chip_rst | output | 1 | Internal chip reset pulse |
| irq_interval | output | 1 | Interval-mode wrap interrupt |

## Verification
The checker watches these rules on every cycle:
- The reset pulse never runs longer than 8 cycles, and it always ends after exactly 8 unless standby cut it short.
- The counter and the timer are held at their initial values while the pulse is high.
- The interval interrupt lasts a single cycle.
- The overflow flag rises only in watchdog mode.
- The flag falls only under a qualified clear or standby.
- The flag is already set when a pulse begins.

Some rules need an ordered sequence of events, so only the bench's scenarios can show them:
- Clearing the flag needs a prior read, and writing 1 to bit 7 does nothing.
- A fresh overflow cancels an earlier arming read.
- Writes without the key are dropped.
- Writes made during the pulse are discarded.
- The fixed read-back bits of the status register hold.

// File: rtl/wdt_rststat.sv
module wdt_rststat #(
  parameter int          CNT_W     = 8,
  parameter int          PULSE_LEN = 8,
  parameter logic [7:0]  WR_KEY    = 8'h5A
) (
  input  logic        clk,
  input  logic        rst_pin_n,
  input  logic        standby,
  input  logic        tick,
  input  logic [1:0]  addr,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  input  logic        rd_en,
  output logic [7:0]  rd_data,
  output logic        chip_rst,
  output logic        irq_interval
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             mode_q, run_q;
  logic             ovf_q, rsten_q, armed_q;
  logic [PW-1:0]    pulse_q;
  logic             irq_q;

  wire holding = (pulse_q != '0);
  wire step    = run_q && tick && !holding;
  wire wrap    = step && (cnt_q == '1);
  wire wd_wrap = wrap && mode_q;
  wire iv_wrap = wrap && !mode_q;
  wire fire    = wd_wrap && rsten_q;
  wire key_ok  = (wr_data[15:8] == WR_KEY);
  wire cnt_wr  = wr_en && (addr == 2'd0);
  wire ctl_wr  = wr_en && (addr == 2'd1);
  wire st_wr   = wr_en && (addr == 2'd2) && key_ok;
  wire st_rd   = rd_en && (addr == 2'd2);

  always_ff @(posedge clk or negedge rst_pin_n) begin
    if (!rst_pin_n) begin
      cnt_q  <= '0;
      mode_q <= 1'b0;
      run_q  <= 1'b0;
    end else if (standby || holding || wd_wrap) begin
      cnt_q  <= '0;
      mode_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      if (cnt_wr)    cnt_q <= CNT_W'(wr_data[7:0]);
      else if (step) cnt_q <= cnt_q + 1'b1;
      if (ctl_wr) begin
        mode_q <= wr_data[6];
        run_q  <= wr_data[5];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_pin_n) begin
    if (!rst_pin_n) begin
      pulse_q <= '0;
      irq_q   <= 1'b0;
    end else if (standby) begin
      pulse_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= iv_wrap;
      if (fire)         pulse_q <= PW'(PULSE_LEN);
      else if (holding) pulse_q <= pulse_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_pin_n) begin
    if (!rst_pin_n) begin
      ovf_q   <= 1'b0;
      rsten_q <= 1'b0;
      armed_q <= 1'b0;
    end else if (standby) begin
      ovf_q   <= 1'b0;
      rsten_q <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (wd_wrap) begin
        ovf_q   <= 1'b1;
        armed_q <= 1'b0;
      end else if (st_wr && !wr_data[7] && armed_q) begin
        ovf_q   <= 1'b0;
        armed_q <= 1'b0;
      end else if (st_rd && ovf_q) begin
        armed_q <= 1'b1;
      end
      if (st_wr) rsten_q <= wr_data[6];
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (rd_en) begin
      case (addr)
        2'd0:    rd_data = 8'(cnt_q);
        2'd1:    rd_data = {1'b0, mode_q, run_q, 5'b00000};
        2'd2:    rd_data = {ovf_q, rsten_q, 6'b011111};
        default: rd_data = 8'h00;
      endcase
    end
  end

  assign chip_rst     = holding;
  assign irq_interval = irq_q;
endmodule

// File: rtl/wdt_rststat_chk.sv
module wdt_rststat_chk #(
  parameter int         CNT_W     = 8,
  parameter int         PULSE_LEN = 8,
  parameter logic [7:0] WR_KEY    = 8'h5A
) (
  input logic             clk,
  input logic             rst_pin_n,
  input logic             standby,
  input logic             chip_rst,
  input logic             irq_interval,
  input logic             ovf,
  input logic             armed,
  input logic             mode,
  input logic             run,
  input logic [CNT_W-1:0] cnt,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic [7:0]       wr_key,
  input logic             wr_b7
);
  localparam int HW = $clog2(PULSE_LEN + 2);
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_pin_n) begin
    if (!rst_pin_n)    hi_cnt <= '0;
    else if (chip_rst) hi_cnt <= hi_cnt + 1'b1;
    else               hi_cnt <= '0;
  end

  AST_PULSE_MAX: assert property (@(posedge clk) disable iff (!rst_pin_n)
    hi_cnt <= HW'(PULSE_LEN)); // R5
  AST_PULSE_FULL: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $fell(chip_rst) |-> (hi_cnt == HW'(PULSE_LEN) || $past(standby))); // R5
  AST_HOLD_IN_RESET: assert property (@(posedge clk) disable iff (!rst_pin_n)
    chip_rst |-> (cnt == '0 && !run && !mode)); // R5
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_pin_n)
    irq_interval |=> !irq_interval); // R4
  AST_FLAG_WD_ONLY: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $rose(ovf) |-> $past(mode)); // R3
  AST_FLAG_CLEAR_RULE: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $fell(ovf) |-> $past(standby || (wr_en && addr == 2'd2 && wr_key == WR_KEY && !wr_b7 && armed))); // R8
  AST_PULSE_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $rose(chip_rst) |-> ovf); // R7
endmodule

bind wdt_rststat wdt_rststat_chk #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN), .WR_KEY(WR_KEY)) u_chk (
  .clk(clk), .rst_pin_n(rst_pin_n), .standby(standby), .chip_rst(chip_rst),
  .irq_interval(irq_interval), .ovf(ovf_q), .armed(armed_q), .mode(mode_q),
  .run(run_q), .cnt(cnt_q), .wr_en(wr_en), .addr(addr),
  .wr_key(wr_data[15:8]), .wr_b7(wr_data[7])
);

// File: tb/sim_wdt_rststat.sv
module sim_wdt_rststat;
  logic clk = 1'b0, rst_pin_n = 1'b0, standby = 1'b0, tick = 1'b0;
  logic [1:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [7:0] rd_data;
  logic chip_rst, irq_interval;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  wdt_rststat u0 (.clk(clk), .rst_pin_n(rst_pin_n), .standby(standby), .tick(tick),
    .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .chip_rst(chip_rst), .irq_interval(irq_interval));

  // {key, write byte, expected read-back, unused}
  localparam logic [31:0] VEC [6] = '{
    32'h5AC05F00, 32'h00005F00, 32'h5A3F1F00,
    32'hA5401F00, 32'h5A7F5F00, 32'h5A001F00
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rd_data;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic wd_overflow();
    wr(2'd1, 16'h0060);
    wr(2'd0, 16'h00FF);
    ticks(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int hi;
    logic first_hi;
    repeat (3) @(negedge clk);
    rst_pin_n = 1'b1;

    rd(2'd2, d); chk("R1 status after pin reset", d, 8'h1F);
    rd(2'd0, d); chk("R1 counter after pin reset", d, 8'h00);
    rd(2'd1, d); chk("R1 control after pin reset", d, 8'h00);
    chk("R1 chip_rst after pin reset", {7'b0, chip_rst}, 8'h00);

    for (int i = 0; i < 6; i++) begin
      wr(2'd2, {VEC[i][31:24], VEC[i][23:16]});
      rd(2'd2, d);
      chk($sformatf("R10 R11 vector %0d", i), d, VEC[i][15:8]);
    end

    wr(2'd0, 16'h0010);
    ticks(3);
    rd(2'd0, d); chk("R2 hold while stopped", d, 8'h10);
    wr(2'd1, 16'h0020);
    ticks(5);
    rd(2'd0, d); chk("R2 count by ticks", d, 8'h15);

    wr(2'd0, 16'h00FE);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); #1 chk("R4 no irq before wrap", {7'b0, irq_interval}, 8'h00);
    @(negedge clk); #1 chk("R4 irq at wrap", {7'b0, irq_interval}, 8'h01);
    tick = 1'b0;
    @(negedge clk); #1 chk("R4 irq one cycle", {7'b0, irq_interval}, 8'h00);
    rd(2'd2, d); chk("R4 no flag in interval mode", d, 8'h1F);
    ticks(2);
    rd(2'd0, d); chk("R4 counter keeps running", d, 8'h02);

    wd_overflow();
    #1 chk("R6 no chip reset when disabled", {7'b0, chip_rst}, 8'h00);
    rd(2'd1, d); chk("R6 control back to initial", d, 8'h00);
    rd(2'd0, d); chk("R6 counter at zero", d, 8'h00);
    wr(2'd2, 16'h5A00);
    rd(2'd2, d); chk("R3 R8 flag set, write 0 without read kept", d, 8'h9F);
    wr(2'd2, 16'h5A80);
    rd(2'd2, d); chk("R8 writing 1 has no effect", d, 8'h9F);
    wr(2'd2, 16'h1200);
    rd(2'd2, d); chk("R10 unkeyed clear ignored", d, 8'h9F);
    wr(2'd2, 16'h5A00);
    rd(2'd2, d); chk("R8 read then write 0 clears", d, 8'h1F);

    wd_overflow();
    rd(2'd2, d); chk("R9 flag set again", d, 8'h9F);
    wd_overflow();
    wr(2'd2, 16'h5A00);
    rd(2'd2, d); chk("R9 new overflow cancels arming", d, 8'h9F);
    wr(2'd2, 16'h5A00);
    rd(2'd2, d); chk("R9 clear after fresh read", d, 8'h1F);

    wr(2'd2, 16'h5A40);
    wd_overflow();
    hi = 0;
    first_hi = 1'b0;
    addr = 2'd1; wr_data = 16'h0060; wr_en = 1'b1;
    for (int i = 0; i < 12; i++) begin
      #1 if (chip_rst) hi++;
      if (i == 0) first_hi = chip_rst;
      @(negedge clk);
      if (i == 0) wr_en = 1'b0;
    end
    chk("R5 pulse starts after wrap", {7'b0, first_hi}, 8'h01);
    chk("R5 pulse length", 8'(hi), 8'h08);
    rd(2'd1, d); chk("R5 control write during pulse ignored", d, 8'h00);
    rd(2'd0, d); chk("R5 counter held at zero", d, 8'h00);
    rd(2'd2, d); chk("R7 status kept through chip reset", d, 8'hDF);

    @(negedge clk); standby = 1'b1;
    @(negedge clk); standby = 1'b0;
    rd(2'd2, d); chk("R1 status after standby", d, 8'h1F);
    chk("R1 chip_rst after standby", {7'b0, chip_rst}, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule